// File: doc/BRIEF.md
# Tile and Sprite Scanline Renderer

This block builds one 256-pixel game line at a time into an external line buffer, without a frame buffer. A pulse on `line_start` launches a render of line `line_num`, with the scroll offsets sampled at that pulse. The block reads video SRAM one byte per cycle. It first paints the background tiles for the whole line from left to right, with horizontal and vertical scroll applied. It then walks the 64-entry sprite attribute table and overlays up to 16 visible 8x8 sprites. Each pixel written to the line buffer is a 2-bit palette select and a 4-bit colour index.

When both passes are done, the renderer parks in a wait state. It raises `line_done` for one cycle, and that pulse can drive a CPU interrupt for the rest of the display time. The control side is reduced to the line number and the two scroll registers. Display, scan doubling and palette lookup are handled elsewhere.

Top module: `scanline_renderer`

## Requirements
- R1: After reset `busy`, `line_done` and `lb_we` are low, and they stay low until `line_start` is seen.
- R2: A `line_start` pulse sampled while idle raises `busy` on the next cycle. On completion `busy` falls and `line_done` is high for exactly one cycle. No write happens while idle, except the final write that lands with the `line_done` cycle.
- R3: The background pass writes every x from 0 to 255 exactly once, in ascending order, before any sprite write. The tile map is 32x32 bytes, row-major, at `MAP_BASE`. A map byte holds the tile number in bits 5:0 and the palette in bits 7:6. A tile takes 32 pattern bytes at `PAT_BASE + tile*32`: 4 bytes per row, 2 pixels per byte, with the left pixel in the high nibble. `lb_data` is {palette[1:0], index[3:0]}.
- R4: The background pixel at screen x on line L is taken from world position ((x + scroll_x) mod 256, (L + scroll_y) mod 256), so both axes wrap.
- R5: Sprite entry i takes 4 bytes at `SAT_BASE + 4*i`: Y, X, tile, and palette (bits 1:0). The sprite is visible when d = (L - Y) mod 256 is below 8. It then uses pattern row d of the 32-byte tile at `SPAT_BASE + tile*32`, laid out like background tiles.
- R6: A sprite pixel with colour index 0 is transparent and leaves the pixel below it unchanged.
- R7: Where sprites overlap, the one with the lower table index wins.
- R8: At most 16 sprites are drawn per line: the first 16 visible entries in table order. Later visible entries leave no pixels.
- R9: Sprite pixels with X + column greater than 255 are dropped and do not wrap to the left edge.
- R10: `line_done` rises no later than 540 cycles after the edge that samples `line_start`, even with 16 visible sprites.
- R11: A `line_start` pulse while `busy` is ignored: the line in progress completes unchanged and only one `line_done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Start-of-line pulse |
| line_num | input | 8 | Game line to render, sampled at start |
| scroll_x | input | 8 | Horizontal scroll, sampled at start |
| scroll_y | input | 8 | Vertical scroll, sampled at start |
| vram_addr | output | ADDR_W | Video SRAM byte address |
| vram_rdata | input | 8 | Video SRAM read data for `vram_addr`, same cycle |
| lb_we | output | 1 | Line buffer write strobe |
| lb_addr | output | 8 | Line buffer pixel position |
| lb_data | output | 6 | {palette, colour index} |
| busy | output | 1 | Render in progress |
| line_done | output | 1 | One-cycle end-of-line pulse (interrupt request) |

## Verification
The bench targets the fine-scroll seam, where a design that mishandles the partial first and last tile columns either writes x positions twice or skips some, and the bottom-of-map vertical wrap. For sprites it stacks overlapping entries and transparent nibbles. A design with the wrong priority shows the later sprite on top, and one without the transparency rule paints colour-0 holes over the background. It loads 20 visible sprites to confirm that the 17th and later leave no trace and that the worst case still meets the cycle budget. It places a sprite at X=252 to catch pixels that wrap to x 0..3, and pulses `line_start` mid-render to catch a renderer that restarts or reports two completions.

// File: rtl/rndr_pkg.sv
package rndr_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_BG_MAP,
    ST_BG_PIX,
    ST_SP_Y,
    ST_SP_X,
    ST_SP_T,
    ST_SP_P,
    ST_SP_PIX
  } rstate_t;

  // Left pixel of a byte sits in the high nibble.
  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic odd);
    return odd ? b[3:0] : b[7:4];
  endfunction

  // 32 bytes per tile, 4 bytes per row, 2 pixels per byte.
  function automatic logic [12:0] pat_offset(input logic [7:0] tile, input logic [2:0] row,
                                             input logic [2:0] col);
    return {tile, row, col[2:1]};
  endfunction

  // 32x32 map, row-major.
  function automatic logic [9:0] map_offset(input logic [7:0] world_y, input logic [4:0] tcol);
    return {world_y[7:3], tcol};
  endfunction

  function automatic logic [7:0] row_delta(input logic [7:0] line, input logic [7:0] y);
    return line - y;
  endfunction

  function automatic logic row_hit(input logic [7:0] line, input logic [7:0] y);
    logic [7:0] d;
    d = line - y;
    return d[7:3] == 5'd0;
  endfunction

endpackage

// File: rtl/rndr_addr_mux.sv
module rndr_addr_mux
  import rndr_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int MAP_BASE  = 'h0000,
  parameter int PAT_BASE  = 'h0800,
  parameter int SAT_BASE  = 'h1000,
  parameter int SPAT_BASE = 'h2000,
  parameter int SPR_W     = 6
) (
  input  rstate_t            state,
  input  logic [7:0]         world_y,
  input  logic [4:0]         tcol,
  input  logic [5:0]         bg_tile,
  input  logic [2:0]         k,
  input  logic [SPR_W-1:0]   spr_idx,
  input  logic [7:0]         spr_tile,
  input  logic [2:0]         spr_row,
  output logic [ADDR_W-1:0]  addr
);

  always_comb begin
    case (state)
      ST_BG_MAP: addr = ADDR_W'(MAP_BASE) + ADDR_W'(map_offset(world_y, tcol));
      ST_BG_PIX: addr = ADDR_W'(PAT_BASE) + ADDR_W'(pat_offset({2'b00, bg_tile}, world_y[2:0], k));
      ST_SP_Y:   addr = ADDR_W'(SAT_BASE) + ADDR_W'({spr_idx, 2'd0});
      ST_SP_X:   addr = ADDR_W'(SAT_BASE) + ADDR_W'({spr_idx, 2'd1});
      ST_SP_T:   addr = ADDR_W'(SAT_BASE) + ADDR_W'({spr_idx, 2'd2});
      ST_SP_P:   addr = ADDR_W'(SAT_BASE) + ADDR_W'({spr_idx, 2'd3});
      ST_SP_PIX: addr = ADDR_W'(SPAT_BASE) + ADDR_W'(pat_offset(spr_tile, spr_row, k));
      default:   addr = '0;
    endcase
  end

endmodule

// File: rtl/rndr_claim_mask.sv
module rndr_claim_mask #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             set_en,
  input  logic [POS_W-1:0] pos,
  output logic             hit
);

  localparam int SLOTS = 1 << POS_W;

  logic [SLOTS-1:0] mask;

  assign hit = mask[pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (clear)  mask <= '0;
    else if (set_en) mask[pos] <= 1'b1;
  end

endmodule

// File: rtl/rndr_lb_writer.sv
module rndr_lb_writer #(
  parameter int POS_W = 8,
  parameter int PIX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_in,
  input  logic             spr_in,
  input  logic [POS_W-1:0] pos_in,
  input  logic [PIX_W-1:0] pix_in,
  output logic             we,
  output logic             is_spr,
  output logic [POS_W-1:0] pos,
  output logic [PIX_W-1:0] pix
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we     <= 1'b0;
      is_spr <= 1'b0;
      pos    <= '0;
      pix    <= '0;
    end else begin
      we     <= we_in;
      is_spr <= spr_in;
      pos    <= pos_in;
      pix    <= pix_in;
    end
  end

endmodule

// File: rtl/scanline_renderer.sv
module scanline_renderer
  import rndr_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int MAP_BASE     = 'h0000,
  parameter int PAT_BASE     = 'h0800,
  parameter int SAT_BASE     = 'h1000,
  parameter int SPAT_BASE    = 'h2000,
  parameter int NUM_SPR      = 64,
  parameter int MAX_PER_LINE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [7:0]        line_num,
  input  logic [7:0]        scroll_x,
  input  logic [7:0]        scroll_y,
  output logic [ADDR_W-1:0] vram_addr,
  input  logic [7:0]        vram_rdata,
  output logic              lb_we,
  output logic [7:0]        lb_addr,
  output logic [5:0]        lb_data,
  output logic              busy,
  output logic              line_done
);

  localparam int LINE_PIX = 256;
  localparam int COLS     = LINE_PIX / 8 + 1;  // one extra column for fine scroll
  localparam int COL_W    = $clog2(COLS);
  localparam int P_W      = COL_W + 3;
  localparam int SPR_W    = $clog2(NUM_SPR);
  localparam int CNT_W    = $clog2(MAX_PER_LINE + 1);

  rstate_t          state;
  logic [7:0]       line_r, sx_r, sy_r, bg_map, spr_x, spr_tile;
  logic [2:0]       k, spr_row;
  logic [1:0]       spr_pal;
  logic [COL_W-1:0] col;
  logic [SPR_W-1:0] spr_idx;
  logic [CNT_W-1:0] drawn;
  logic             done_r;

  // Named events, also watched by the checker.
  logic             start_accept, bg_wr, spr_wr, px_we, claimed, lb_is_spr;
  logic             last_k, last_col, last_entry, cap_hit;
  logic [7:0]       world_y, px_addr;
  logic [4:0]       tcol;
  logic [P_W-1:0]   bg_p, bg_off, fine;
  logic             bg_in;
  logic [3:0]       nib;
  logic [8:0]       spr_xp;
  logic [5:0]       px_data;

  always_comb begin
    world_y      = line_r + sy_r;
    tcol         = sx_r[7:3] + col[4:0];
    fine         = P_W'(sx_r[2:0]);
    bg_p         = {col, k};
    bg_off       = bg_p - fine;
    bg_in        = (bg_p >= fine) && (bg_off[P_W-1:8] == '0);
    nib          = pick_nibble(vram_rdata, k[0]);
    spr_xp       = {1'b0, spr_x} + {6'b0, k};
    last_k       = (k == 3'd7);
    last_col     = (col == COL_W'(COLS - 1));
    last_entry   = (spr_idx == SPR_W'(NUM_SPR - 1));
    cap_hit      = (drawn == CNT_W'(MAX_PER_LINE - 1));
    start_accept = line_start && (state == ST_WAIT);
    bg_wr        = (state == ST_BG_PIX) && bg_in;
    spr_wr       = (state == ST_SP_PIX) && (nib != 4'd0) && !spr_xp[8] && !claimed;
    px_we        = bg_wr || spr_wr;
    px_addr      = (state == ST_SP_PIX) ? spr_xp[7:0] : bg_off[7:0];
    px_data      = (state == ST_SP_PIX) ? {spr_pal, nib} : {bg_map[7:6], nib};
  end

  rndr_addr_mux #(
    .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE), .PAT_BASE(PAT_BASE),
    .SAT_BASE(SAT_BASE), .SPAT_BASE(SPAT_BASE), .SPR_W(SPR_W)
  ) u_addr (
    .state(state), .world_y(world_y), .tcol(tcol), .bg_tile(bg_map[5:0]), .k(k),
    .spr_idx(spr_idx), .spr_tile(spr_tile), .spr_row(spr_row), .addr(vram_addr)
  );

  rndr_claim_mask #(.POS_W(8)) u_claim (
    .clk(clk), .rst_n(rst_n), .clear(start_accept), .set_en(spr_wr),
    .pos(spr_xp[7:0]), .hit(claimed)
  );

  rndr_lb_writer #(.POS_W(8), .PIX_W(6)) u_wr (
    .clk(clk), .rst_n(rst_n), .we_in(px_we), .spr_in(state == ST_SP_PIX),
    .pos_in(px_addr), .pix_in(px_data),
    .we(lb_we), .is_spr(lb_is_spr), .pos(lb_addr), .pix(lb_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_WAIT;
      line_r   <= '0;
      sx_r     <= '0;
      sy_r     <= '0;
      bg_map   <= '0;
      spr_x    <= '0;
      spr_tile <= '0;
      spr_row  <= '0;
      spr_pal  <= '0;
      k        <= '0;
      col      <= '0;
      spr_idx  <= '0;
      drawn    <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        ST_WAIT: if (line_start) begin
          line_r <= line_num;
          sx_r   <= scroll_x;
          sy_r   <= scroll_y;
          col    <= '0;
          state  <= ST_BG_MAP;
        end
        ST_BG_MAP: begin
          bg_map <= vram_rdata;
          k      <= '0;
          state  <= ST_BG_PIX;
        end
        ST_BG_PIX: begin
          k <= k + 3'd1;
          if (last_k) begin
            if (last_col) begin
              spr_idx <= '0;
              drawn   <= '0;
              state   <= ST_SP_Y;
            end else begin
              col   <= col + COL_W'(1);
              state <= ST_BG_MAP;
            end
          end
        end
        ST_SP_Y: begin
          if (row_hit(line_r, vram_rdata)) begin
            spr_row <= row_delta(line_r, vram_rdata)[2:0];
            state   <= ST_SP_X;
          end else if (last_entry) begin
            state  <= ST_WAIT;
            done_r <= 1'b1;
          end else begin
            spr_idx <= spr_idx + SPR_W'(1);
          end
        end
        ST_SP_X: begin
          spr_x <= vram_rdata;
          state <= ST_SP_T;
        end
        ST_SP_T: begin
          spr_tile <= vram_rdata;
          state    <= ST_SP_P;
        end
        ST_SP_P: begin
          spr_pal <= vram_rdata[1:0];
          k       <= '0;
          state   <= ST_SP_PIX;
        end
        ST_SP_PIX: begin
          k <= k + 3'd1;
          if (last_k) begin
            drawn <= drawn + CNT_W'(1);
            if (cap_hit || last_entry) begin
              state  <= ST_WAIT;
              done_r <= 1'b1;
            end else begin
              spr_idx <= spr_idx + SPR_W'(1);
              state   <= ST_SP_Y;
            end
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  assign busy      = (state != ST_WAIT);
  assign line_done = done_r;

endmodule

// File: rtl/rndr_checker.sv
module rndr_checker #(
  parameter int MAX_PER_LINE = 16,
  parameter int CNT_W        = 5,
  parameter int BUDGET       = 540
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             line_done,
  input logic             lb_we,
  input logic             lb_is_spr,
  input logic [7:0]       lb_addr,
  input logic [3:0]       lb_nib,
  input logic [CNT_W-1:0] drawn
);

  logic [7:0]  bg_next;
  logic [15:0] busy_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_next  <= '0;
      busy_cyc <= '0;
    end else begin
      if (lb_we && !lb_is_spr) bg_next <= bg_next + 8'd1;
      if (!busy)                   busy_cyc <= '0;
      else if (busy_cyc != 16'hFFFF) busy_cyc <= busy_cyc + 16'd1;
    end
  end

  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we |-> (busy || line_done));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !busy);

  assert_bg_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_we && !lb_is_spr) |-> (lb_addr == bg_next));

  assert_spr_after_bg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_we && lb_is_spr) |-> (bg_next == 8'd0));

  assert_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_we && lb_is_spr) |-> (lb_nib != 4'd0));

  assert_sprite_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drawn <= CNT_W'(MAX_PER_LINE));

  assert_budget_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cyc < 16'(BUDGET)));

endmodule

bind scanline_renderer rndr_checker #(
  .MAX_PER_LINE(MAX_PER_LINE), .CNT_W(CNT_W), .BUDGET(540)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .line_done(line_done),
  .lb_we(lb_we), .lb_is_spr(lb_is_spr), .lb_addr(lb_addr),
  .lb_nib(lb_data[3:0]), .drawn(drawn)
);

// File: tb/sim_scanline_renderer.sv
`timescale 1ns/1ps
module sim_scanline_renderer;

  localparam int MAP  = 'h0000;
  localparam int PAT  = 'h0800;
  localparam int SAT  = 'h1000;
  localparam int SPAT = 'h2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [7:0]  line_num = '0, scroll_x = '0, scroll_y = '0;
  logic [14:0] vram_addr;
  logic [7:0]  vram_rdata;
  logic        lb_we, busy, line_done;
  logic [7:0]  lb_addr;
  logic [5:0]  lb_data;

  logic [7:0]  mem [0:32767];
  logic [6:0]  lbuf [0:255];
  logic [5:0]  expv [0:255];
  int          checks = 0, fails = 0, wrcnt = 0, done_seen = 0;
  bit          order_bad = 0, finished = 0;

  always #2 clk = ~clk;

  assign vram_rdata = mem[vram_addr];

  scanline_renderer u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .vram_addr(vram_addr),
    .vram_rdata(vram_rdata), .lb_we(lb_we), .lb_addr(lb_addr), .lb_data(lb_data),
    .busy(busy), .line_done(line_done)
  );

  always @(negedge clk) begin
    if (lb_we) begin
      if (wrcnt < 256 && int'(lb_addr) != wrcnt) order_bad = 1;
      lbuf[lb_addr] = {1'b0, lb_data};
      wrcnt++;
    end
    if (line_done) done_seen++;
  end

  task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input logic [7:0] b, input int px);
    return (px % 2 == 1) ? b[3:0] : b[7:4];
  endfunction

  function automatic logic [5:0] bg_pix(input int ln, input int sx, input int sy, input int x);
    int wx, wy;
    logic [7:0] m, b;
    wx = (x + sx) % 256;
    wy = (ln + sy) % 256;
    m  = mem[MAP + (wy / 8) * 32 + wx / 8];
    b  = mem[PAT + int'(m[5:0]) * 32 + (wy % 8) * 4 + (wx % 8) / 2];
    return {m[7:6], nib_of(b, wx)};
  endfunction

  task automatic build_exp(input int ln, input int sx, input int sy);
    bit taken [0:255];
    int cnt;
    for (int x = 0; x < 256; x++) begin
      expv[x]  = bg_pix(ln, sx, sy, x);
      taken[x] = 0;
    end
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      int d, xs, t;
      if (cnt < 16) begin
        d = (ln - int'(mem[SAT + i*4]) + 256) % 256;
        if (d < 8) begin
          xs = mem[SAT + i*4 + 1];
          t  = mem[SAT + i*4 + 2];
          for (int c = 0; c < 8; c++) begin
            logic [3:0] ix;
            ix = nib_of(mem[SPAT + t*32 + d*4 + c/2], c);
            if (xs + c < 256 && ix != 0 && !taken[xs + c]) begin
              expv[xs + c]  = {mem[SAT + i*4 + 3][1:0], ix};
              taken[xs + c] = 1;
            end
          end
          cnt++;
        end
      end
    end
  endtask

  task automatic hide_all(input int ln);
    for (int i = 0; i < 64; i++) mem[SAT + i*4] = 8'((ln + 100) % 256);
  endtask

  task automatic set_spr(input int i, input int y, input int x, input int t, input int p);
    mem[SAT + i*4]     = 8'(y);
    mem[SAT + i*4 + 1] = 8'(x);
    mem[SAT + i*4 + 2] = 8'(t);
    mem[SAT + i*4 + 3] = 8'(p);
  endtask

  task automatic render(input int ln, input int sx, input int sy, input int mid_at, output int cyc);
    @(negedge clk);
    for (int x = 0; x < 256; x++) lbuf[x] = 7'h40;
    wrcnt = 0; order_bad = 0; done_seen = 0;
    line_num = 8'(ln); scroll_x = 8'(sx); scroll_y = 8'(sy); line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    cyc = 1;
    while (!line_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (cyc == mid_at) begin
        line_start = 1'b1; line_num = 8'(ln + 1); scroll_x = 8'(sx + 5);
      end else line_start = 1'b0;
    end
    chk("R2", line_done === 1'b1, "line_done seen", int'(line_done), 1);
    @(negedge clk);
    chk("R2", !line_done && !busy, "pulse ends and idle", int'(line_done) + int'(busy), 0);
  endtask

  task automatic compare_line(input string req);
    int nbad, first;
    nbad = 0; first = -1;
    for (int x = 0; x < 256; x++)
      if (lbuf[x] !== {1'b0, expv[x]}) begin
        nbad++;
        if (first < 0) first = x;
      end
    if (first < 0) first = 0;
    chk(req, nbad == 0, $sformatf("line contents, %0d bad, first x=%0d value", nbad, first),
        int'(lbuf[first]), int'(expv[first]));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1", !busy && !line_done && !lb_we, "idle outputs after reset",
          int'(busy) + int'(line_done) + int'(lb_we), 0);
    end
  endtask

  task automatic t_bg_plain;
    int cyc;
    hide_all(10);
    render(10, 0, 0, 0, cyc);
    build_exp(10, 0, 0);
    compare_line("R3");
    chk("R3", !order_bad && wrcnt == 256, "ascending single bg writes", wrcnt, 256);
  endtask

  task automatic t_scroll;
    int cyc;
    hide_all(37);
    render(37, 13, 250, 0, cyc);
    build_exp(37, 13, 250);
    compare_line("R4");
    chk("R4", !order_bad && wrcnt == 256, "fine-scroll seam writes", wrcnt, 256);
    hide_all(239);
    render(239, 255, 5, 0, cyc);
    build_exp(239, 255, 5);
    compare_line("R4");
  endtask

  task automatic t_sprites;
    int cyc;
    hide_all(50);
    set_spr(0, 46, 100, 1, 2);
    set_spr(1, 50, 104, 2, 1);
    set_spr(3, 43, 10, 3, 3);
    render(50, 0, 0, 0, cyc);
    build_exp(50, 0, 0);
    compare_line("R5");
    chk("R7", lbuf[105] === 7'h22, "overlap pixel x=105", int'(lbuf[105]), 'h22);
    chk("R5", lbuf[108] === 7'h13, "second sprite pixel x=108", int'(lbuf[108]), 'h13);
    chk("R6", lbuf[109] === {1'b0, bg_pix(50, 0, 0, 109)}, "transparent x=109",
        int'(lbuf[109]), int'(bg_pix(50, 0, 0, 109)));
    chk("R6", lbuf[10] === {1'b0, bg_pix(50, 0, 0, 10)}, "transparent x=10",
        int'(lbuf[10]), int'(bg_pix(50, 0, 0, 10)));
    chk("R5", lbuf[11] === 7'h3F, "last-row sprite pixel x=11", int'(lbuf[11]), 'h3F);
  endtask

  task automatic t_cap;
    int cyc;
    hide_all(80);
    for (int i = 44; i < 64; i++) set_spr(i, 77, (i - 44) * 12, 1, i % 4);
    render(80, 0, 0, 0, cyc);
    build_exp(80, 0, 0);
    compare_line("R8");
    chk("R8", lbuf[192] === {1'b0, bg_pix(80, 0, 0, 192)}, "17th sprite absent x=192",
        int'(lbuf[192]), int'(bg_pix(80, 0, 0, 192)));
    chk("R8", lbuf[180] === 7'h31, "16th sprite present x=180", int'(lbuf[180]), 'h31);
    chk("R10", cyc <= 540, "cycles with 20 visible", cyc, 540);
    for (int i = 44; i < 48; i++) mem[SAT + i*4] = 8'd200;
    render(80, 0, 0, 0, cyc);
    chk("R10", cyc <= 540, "cycles, 16 visible at table end", cyc, 540);
  endtask

  task automatic t_clip;
    int cyc;
    hide_all(2);
    set_spr(0, 254, 252, 1, 1);
    render(2, 0, 0, 0, cyc);
    build_exp(2, 0, 0);
    compare_line("R9");
    chk("R9", lbuf[252] === 7'h11, "right-edge pixel x=252", int'(lbuf[252]), 'h11);
    for (int x = 0; x < 4; x++)
      chk("R9", lbuf[x] === {1'b0, bg_pix(2, 0, 0, x)}, $sformatf("no wrap at x=%0d", x),
          int'(lbuf[x]), int'(bg_pix(2, 0, 0, x)));
  endtask

  task automatic t_ignore;
    int cyc;
    hide_all(60);
    set_spr(5, 58, 40, 1, 3);
    render(60, 20, 0, 100, cyc);
    repeat (30) @(negedge clk);
    build_exp(60, 20, 0);
    compare_line("R11");
    chk("R11", done_seen == 1 && !busy, "single completion", done_seen, 1);
  endtask

  initial begin
    for (int a = 0; a < 32768; a++) mem[a] = 8'h00;
    for (int i = 0; i < 1024; i++) mem[MAP + i] = 8'((i * 37 + 11) % 256);
    for (int j = 0; j < 2048; j++) mem[PAT + j] = 8'((j * 29 + 7) % 256);
    for (int j = 0; j < 32; j++) begin
      mem[SPAT + 32 + j] = 8'h12;
      mem[SPAT + 64 + j] = 8'h30;
      mem[SPAT + 96 + j] = 8'h0F;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_bg_plain;
    t_scroll;
    t_sprites;
    t_cap;
    t_clip;
    t_ignore;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule